// File: doc/BRIEF.md
# Dual-Plane Pixel Serializer

This block sits between a bitmap display memory and a monitor. It produces the address of each display word in step with the beam position. Every word it reads back carries eight pixels for a full-intensity plane and eight for a half-intensity plane. Those two bytes go into a pair of shift registers that share one clock, so two serial pixel streams come out side by side. The block has no glyph lookup: anything drawn on screen, text included, is already present as pixels in memory.

An external timing generator supplies the display enable, horizontal sync and vertical sync. The block counts 8-pixel groups along a line. It steps to the next row on each horizontal sync and returns to the top of memory on vertical sync. Both syncs are delayed by the same number of cycles as the pixel pipeline, so they stay aligned with the pixels. Memory is assumed to return a word one clock after its address is presented.

Top module: `dual_plane_serializer`

## Requirements
- R1: While reset is asserted, `memAddr` is zero and `pixFull`, `pixHalf`, `hsyncOut` and `vsyncOut` are low.
- R2: While `dispEn` is high, `memAddr` keeps its value for eight cycles and then rises by one. The step happens in the cycle after the eighth consecutive enabled cycle.
- R3: A line base register starts at zero. It gains `LINE_WORDS` in the cycle after each rising edge of `hsyncIn`. It is cleared in the cycle after any cycle with `vsyncIn` high, and this clear wins over a simultaneous horizontal step. While `dispEn` is low, `memAddr` loads the line base on every clock.
- R4: For each fetched word, bits [15:8] form the full plane and bits [7:0] the half plane, both sent most-significant bit first. Consider a word whose address is on `memAddr` in the first cycle of a group of eight enabled cycles. Its pixel k appears 2+k cycles after that cycle.
- R5: When the full-plane bit and the half-plane bit of a pixel are both set, `pixFull` is high and `pixHalf` is low.
- R6: `pixFull` and `pixHalf` are low in every cycle whose `dispEn` two cycles earlier was low.
- R7: `hsyncOut` and `vsyncOut` equal `hsyncIn` and `vsyncIn` from two cycles earlier.
- R8: When `dispEn` falls in the middle of a group, the group count restarts. The next enabled run begins again at the line base, starting with pixel 0 of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dispEn | input | 1 | Active-video enable from the timing generator |
| hsyncIn | input | 1 | Horizontal sync from the timing generator, active high |
| vsyncIn | input | 1 | Vertical sync from the timing generator, active high |
| memData | input | 2*PIX | Display word read back one cycle after its address |
| memAddr | output | ADDR_W | Display memory word address |
| pixFull | output | 1 | Full-intensity pixel |
| pixHalf | output | 1 | Half-intensity pixel |
| hsyncOut | output | 1 | Horizontal sync aligned to the pixels |
| vsyncOut | output | 1 | Vertical sync aligned to the pixels |

## Verification
The address is a register. Its new value is due one cycle after the enable cycle, phase or sync edge that changes it. The pixel and sync outputs are due two cycles after the cycle that caused them: one cycle for the memory read and one for the shift-register load. The reference model keeps a per-cycle history of inputs, group start addresses and positions within each group. On every cycle it compares the address against the current model value, and it compares the pixels and syncs against the history entry from two cycles back. All sampling happens on the falling clock edge, before new inputs are applied.

// File: rtl/dps_pkg.sv
package dps_pkg;
  // Strobes from the scan control into the pixel datapath.
  typedef struct packed {
    logic load;   // capture a fresh memory word into both planes
    logic shift;  // advance both planes by one pixel
    logic show;   // current MSBs belong to active video
  } ctrlStrobe_t;
endpackage

// File: rtl/dps_scan_ctrl.sv
module dps_scan_ctrl
  import dps_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PIX        = 8,
  parameter int LINE_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dispEn,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  output logic [ADDR_W-1:0] memAddr,
  output ctrlStrobe_t       strobe
);
  localparam int PH_W = (PIX > 1) ? $clog2(PIX) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX - 1);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LINE_WORDS);

  logic [PH_W-1:0]   phase;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] rowBase;
  logic              hsyncPrev;
  logic              enD1;
  logic              loadD1;
  logic              enD2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      addrReg   <= '0;
      rowBase   <= '0;
      hsyncPrev <= 1'b0;
      enD1      <= 1'b0;
      loadD1    <= 1'b0;
      enD2      <= 1'b0;
    end else begin
      hsyncPrev <= hsyncIn;
      if (vsyncIn)                     rowBase <= '0;
      else if (hsyncIn && !hsyncPrev)  rowBase <= rowBase + STRIDE;

      if (dispEn) begin
        if (phase == PH_LAST) begin
          phase   <= '0;
          addrReg <= addrReg + ADDR_W'(1);
        end else begin
          phase   <= phase + PH_W'(1);
        end
      end else begin
        phase   <= '0;
        addrReg <= rowBase;
      end

      enD1   <= dispEn;
      loadD1 <= dispEn && (phase == '0);
      enD2   <= enD1;
    end
  end

  assign memAddr      = addrReg;
  assign strobe.load  = enD1 && loadD1;
  assign strobe.shift = enD1 && !loadD1;
  assign strobe.show  = enD2;

  // R2: address holds inside a group and steps once at its end
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dispEn && (phase != PH_LAST) |=> $stable(memAddr));
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dispEn && (phase == PH_LAST) |=> memAddr == $past(memAddr) + ADDR_W'(1));
  // R3: vertical sync returns the line base to the top
  p_base_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vsyncIn |=> rowBase == '0);
endmodule

// File: rtl/dps_pixel_path.sv
module dps_pixel_path
  import dps_pkg::*;
#(
  parameter int PIX        = 8,
  parameter int SYNC_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [2*PIX-1:0] memData,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  output logic             pixFull,
  output logic             pixHalf,
  output logic             hsyncOut,
  output logic             vsyncOut
);
  logic [PIX-1:0]        fullSr;
  logic [PIX-1:0]        halfSr;
  logic [SYNC_DELAY-1:0] hsPipe;
  logic [SYNC_DELAY-1:0] vsPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fullSr <= '0;
      halfSr <= '0;
    end else if (strobe.load) begin
      fullSr <= memData[2*PIX-1:PIX];
      halfSr <= memData[PIX-1:0];
    end else if (strobe.shift) begin
      fullSr <= fullSr << 1;
      halfSr <= halfSr << 1;
    end
  end

  for (genvar s = 0; s < SYNC_DELAY; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hsPipe[s] <= 1'b0;
        vsPipe[s] <= 1'b0;
      end else if (s == 0) begin
        hsPipe[s] <= hsyncIn;
        vsPipe[s] <= vsyncIn;
      end else begin
        hsPipe[s] <= hsPipe[(s == 0) ? 0 : s-1];
        vsPipe[s] <= vsPipe[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign hsyncOut = hsPipe[SYNC_DELAY-1];
  assign vsyncOut = vsPipe[SYNC_DELAY-1];
  assign pixFull  = strobe.show && fullSr[PIX-1];
  assign pixHalf  = strobe.show && halfSr[PIX-1] && !fullSr[PIX-1];

  // R5: the half plane never lights a pixel the full plane already owns
  p_full_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pixFull |-> !pixHalf);
  // R6: no pixel leaves outside active video
  p_dark_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.show |-> !pixFull && !pixHalf);
endmodule

// File: rtl/dual_plane_serializer.sv
module dual_plane_serializer
  import dps_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PIX        = 8,
  parameter int LINE_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dispEn,
  input  logic              hsyncIn,
  input  logic              vsyncIn,
  input  logic [2*PIX-1:0]  memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixFull,
  output logic              pixHalf,
  output logic              hsyncOut,
  output logic              vsyncOut
);
  // one cycle memory read plus one cycle shift-register load
  localparam int PIPE_DEPTH = 2;

  ctrlStrobe_t strobe;

  dps_scan_ctrl #(.ADDR_W(ADDR_W), .PIX(PIX), .LINE_WORDS(LINE_WORDS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .dispEn(dispEn), .hsyncIn(hsyncIn),
    .vsyncIn(vsyncIn), .memAddr(memAddr), .strobe(strobe)
  );

  dps_pixel_path #(.PIX(PIX), .SYNC_DELAY(PIPE_DEPTH)) path_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .memData(memData),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .pixFull(pixFull),
    .pixHalf(pixHalf), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );
endmodule

// File: tb/dual_plane_serializer_tb_top.sv
`timescale 1ns/1ps
module dual_plane_serializer_tb_top;
  localparam int ADDR_W = 10;
  localparam int PIX = 8;
  localparam int LINE_WORDS = 16;
  localparam int HMAX = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dispEn = 1'b0, hsyncIn = 1'b0, vsyncIn = 1'b0;
  logic [2*PIX-1:0] memData = '0;
  logic [ADDR_W-1:0] memAddr;
  logic pixFull, pixHalf, hsyncOut, vsyncOut;

  always #2.5 clk = ~clk;

  dual_plane_serializer #(.ADDR_W(ADDR_W), .PIX(PIX), .LINE_WORDS(LINE_WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .dispEn(dispEn), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .memData(memData), .memAddr(memAddr), .pixFull(pixFull), .pixHalf(pixHalf),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut)
  );

  function automatic logic [15:0] memWord(input logic [ADDR_W-1:0] a);
    logic [7:0] lo;
    lo = a[7:0];
    memWord = {(lo * 8'd29) ^ {a[9:8], 6'h03}, lo ^ 8'hB6};
  endfunction

  // synchronous-read display memory: word is back one clock after its address
  always @(posedge clk) memData <= memWord(memAddr);

  int nCmp = 0, nBad = 0, nStim = 0;
  bit sEn[HMAX], sH[HMAX], sV[HMAX];
  bit hEn[HMAX], hH[HMAX], hV[HMAX];
  int hGrp[HMAX], hK[HMAX];
  bit doneFlag = 0;

  task automatic seg(input int n, input bit e, input bit h, input bit v);
    for (int i = 0; i < n; i++) begin
      sEn[nStim] = e; sH[nStim] = h; sV[nStim] = v; nStim++;
    end
  endtask

  task automatic chk(input string tag, input string what, input int c, input int got, input int exp);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s %s cycle %0d got %0d expected %0d", tag, what, c, got, exp);
    end
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 20000);
    nCmp++; nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [ADDR_W-1:0] mAddr, mBase, grpAddr;
    int mPhase;
    bit prevH;
    logic [15:0] w;
    bit ef, eh;

    // stimulus plan
    seg(4, 0, 0, 1); seg(3, 0, 0, 0);
    for (int l = 0; l < 3; l++) begin          // full lines
      seg(128, 1, 0, 0); seg(3, 0, 0, 0); seg(4, 0, 1, 0); seg(3, 0, 0, 0);
    end
    seg(13, 1, 0, 0); seg(5, 0, 0, 0);         // R8: drop mid-group
    seg(20, 1, 0, 0); seg(2, 0, 0, 0); seg(3, 0, 1, 0); seg(3, 0, 0, 0);
    seg(3, 0, 1, 1); seg(4, 0, 0, 0);          // R3: vsync beats hsync
    seg(40, 1, 0, 0); seg(3, 0, 0, 0); seg(2, 0, 1, 0); seg(3, 0, 0, 0);
    seg(1, 1, 0, 0); seg(4, 0, 0, 0); seg(9, 1, 0, 0); seg(6, 0, 0, 0);

    // R1: reset values
    repeat (3) begin
      @(negedge clk);
      chk("R1", "memAddr", -1, int'(memAddr), 0);
      chk("R1", "pixels", -1, int'({pixFull, pixHalf}), 0);
      chk("R1", "syncs", -1, int'({hsyncOut, vsyncOut}), 0);
    end
    rst_n = 1'b1;

    mAddr = '0; mBase = '0; mPhase = 0; prevH = 0; grpAddr = '0;
    for (int c = 0; c < nStim + 4; c++) begin
      bit e, h, v;
      // outputs of cycle c
      chk("R2/R3/R8", "memAddr", c, int'(memAddr), int'(mAddr));
      if (c >= 2 && hEn[c-2]) begin
        w = memWord(ADDR_W'(hGrp[c-2]));
        ef = w[15 - hK[c-2]];
        eh = w[7 - hK[c-2]] & ~ef;
        chk("R4", "pixFull", c, int'(pixFull), int'(ef));
        chk("R5", "pixHalf", c, int'(pixHalf), int'(eh));
      end else begin
        chk("R6", "pixels idle", c, int'({pixFull, pixHalf}), 0);
      end
      chk("R7", "hsyncOut", c, int'(hsyncOut), (c >= 2) ? int'(hH[c-2]) : 0);
      chk("R7", "vsyncOut", c, int'(vsyncOut), (c >= 2) ? int'(hV[c-2]) : 0);

      // inputs for cycle c
      e = (c < nStim) ? sEn[c] : 1'b0;
      h = (c < nStim) ? sH[c] : 1'b0;
      v = (c < nStim) ? sV[c] : 1'b0;
      dispEn = e; hsyncIn = h; vsyncIn = v;

      if (e && mPhase == 0) grpAddr = mAddr;
      hEn[c] = e; hH[c] = h; hV[c] = v;
      hGrp[c] = int'(grpAddr); hK[c] = mPhase;

      // model step
      if (e) begin
        if (mPhase == PIX - 1) mAddr = mAddr + 1'b1;
        mPhase = (mPhase + 1) % PIX;
      end else begin
        mAddr = mBase;
        mPhase = 0;
      end
      if (v) mBase = '0;
      else if (h && !prevH) mBase = mBase + ADDR_W'(LINE_WORDS);
      prevH = h;
      @(negedge clk);
    end
    summary();
  end
endmodule